// File: doc/BRIEF.md
# Protected Power-Path Mode Sequencer

This block is the digital controller of a protected switch that connects an external supply input to a system output. It takes two mode pins and a set of comparator results that are already digital: input above the undervoltage level, input above the normal overvoltage level, input above the raised overvoltage level, and die temperature within limits. From these it drives a single enable for the pass switch and an active-low fault flag. A millisecond tick sets the pace of two delays in a row. The first delay holds the switch open after the input becomes healthy. The second holds the flag low after the switch has closed.

Any fault opens the switch and pulls the flag low on the next clock edge. When the fault clears, the sequence starts again from the open state. A change of mode pins also restarts it. In the mode that isolates the path, the flag still shows the health of the input. In the reverse-supply mode the input comparators are ignored, and only the temperature comparator can open the switch. All interfaces are plain level-sensitive control and status pins. Nothing flows as a stream, so no valid/ready handshake exists.

Top module: `pwr_path_seq`

## Requirements
- R1: The mode is the two-bit value {dir_pin, rev_pin}. 00 is Enhance, 01 is Direct, 10 is Reverse and 11 is Disable. Both pins pass through a two-flop synchroniser. A pin change therefore acts on the outputs on the third rising edge after it.
- R2: In Enhance or Direct with no fault, the switch (sw_en) closes once T_ON_TICKS ticks have been counted after the sequence leaves the open state.
- R3: In Enhance or Direct, flag_n stays low while the switch-on delay runs. It rises T_FLAG_TICKS ticks after the switch has closed.
- R4: In Enhance or Direct, uv_ok low or the active overvoltage input high makes sw_en and flag_n low on the next edge. After the fault clears, both delays run again in full.
- R5: Direct checks ov_trip and ignores ov_hi_trip. Enhance checks ov_hi_trip and ignores ov_trip.
- R6: In Disable, sw_en stays low. flag_n is high one edge after the input is healthy (uv_ok high, ov_trip low) and low one edge after it is not.
- R7: In Reverse, uv_ok, ov_trip and ov_hi_trip are ignored. With temperature good, the switch closes and the flag rises one edge after the open state, with no delay.
- R8: temp_ok low drops sw_en and flag_n on the next edge in every mode. Once it returns high, the mode's normal sequence restarts from the open state.
- R9: A change of decoded mode aborts any delay in progress and restarts the sequence from the open state.
- R10: During and right after reset, sw_en and flag_n are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per millisecond |
| dir_pin | input | 1 | Mode select, upper bit |
| rev_pin | input | 1 | Mode select, lower bit |
| uv_ok | input | 1 | Input is above the undervoltage level |
| ov_trip | input | 1 | Input is above the normal overvoltage level |
| ov_hi_trip | input | 1 | Input is above the raised overvoltage level |
| temp_ok | input | 1 | Die temperature is within limits |
| sw_en | output | 1 | Pass switch enable |
| flag_n | output | 1 | Fault flag, low when a fault is present or the path is not yet settled |

## Verification
Each result has a fixed latency, and the checks follow it:
- Comparator faults and temperature faults reach both outputs one edge after they appear.
- Mode pins take three edges (two synchroniser stages plus the sequencer register).
- The delays finish on the edge that samples the T_ON_TICKS-th or T_FLAG_TICKS-th tick.

The bench runs a behavioural model that applies these latencies and compares both outputs with it at every falling edge, after the registers have settled. Directed checks are placed a margin of cycles inside the windows set by the sync latency and the tick-counted delays. They confirm each mode's rule and each abort case at the ports.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    MD_ENH = 2'b00,
    MD_DIR = 2'b01,
    MD_REV = 2'b10,
    MD_DIS = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_OPEN     = 3'd0,
    ST_DLY_SW   = 3'd1,
    ST_DLY_FLAG = 3'd2,
    ST_RUN      = 3'd3,
    ST_HOLD     = 3'd4
  } seq_st_e;
endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pps_fault_eval.sv
module pps_fault_eval
  import pps_pkg::*;
(
  input  mode_e mode,
  input  logic  uv_ok,
  input  logic  ov_trip,
  input  logic  ov_hi_trip,
  input  logic  temp_ok,
  output logic  fault
);
  logic ov_sel;
  logic in_fault;

  always_comb begin
    ov_sel   = (mode == MD_ENH) ? ov_hi_trip : ov_trip;
    in_fault = !uv_ok || ov_sel;
    fault    = !temp_ok || ((mode != MD_REV) && in_fault);
  end
endmodule

// File: rtl/pps_tick_cnt.sv
module pps_tick_cnt #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  assign done = step && (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             cnt_q <= '0;
    else if (clr || done)   cnt_q <= '0;
    else if (step)          cnt_q <= cnt_q + CW'(1);
endmodule

// File: rtl/pwr_path_seq.sv
module pwr_path_seq
  import pps_pkg::*;
#(
  parameter int T_ON_TICKS   = 30,
  parameter int T_FLAG_TICKS = 30,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic dir_pin,
  input  logic rev_pin,
  input  logic uv_ok,
  input  logic ov_trip,
  input  logic ov_hi_trip,
  input  logic temp_ok,
  output logic sw_en,
  output logic flag_n
);
  localparam int MAXT = (T_ON_TICKS > T_FLAG_TICKS) ? T_ON_TICKS : T_FLAG_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic [1:0] pins_s;
  mode_e      mode_s, mode_prev;
  logic       fault, mode_chg, abort_seq;
  logic       in_dly, step, done;
  logic [CW-1:0] limit;
  seq_st_e    st_q, st_d;

  pps_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dir_pin, rev_pin}), .q(pins_s)
  );

  assign mode_s = mode_e'(pins_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_prev <= MD_DIS;
    else        mode_prev <= mode_s;

  pps_fault_eval u_fault (
    .mode(mode_s), .uv_ok(uv_ok), .ov_trip(ov_trip),
    .ov_hi_trip(ov_hi_trip), .temp_ok(temp_ok), .fault(fault)
  );

  assign mode_chg  = (mode_s != mode_prev);
  assign abort_seq = fault || mode_chg;
  assign in_dly    = (st_q == ST_DLY_SW) || (st_q == ST_DLY_FLAG);
  assign step      = tick && in_dly && !abort_seq;
  assign limit     = (st_q == ST_DLY_FLAG) ? CW'(T_FLAG_TICKS) : CW'(T_ON_TICKS);

  pps_tick_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(abort_seq || !in_dly),
    .step(step), .limit(limit), .done(done)
  );

  always_comb begin
    st_d = st_q;
    if (abort_seq) st_d = ST_OPEN;
    else begin
      case (st_q)
        ST_OPEN: begin
          case (mode_s)
            MD_DIS:  st_d = ST_HOLD;
            MD_REV:  st_d = ST_RUN;
            default: st_d = ST_DLY_SW;
          endcase
        end
        ST_DLY_SW:   if (done) st_d = ST_DLY_FLAG;
        ST_DLY_FLAG: if (done) st_d = ST_RUN;
        default:     st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= ST_OPEN;
    else        st_q <= st_d;

  assign sw_en  = (st_q == ST_DLY_FLAG) || (st_q == ST_RUN);
  assign flag_n = (st_q == ST_RUN) || (st_q == ST_HOLD);

  // R4
  fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!sw_en && !flag_n));

  // R8
  therm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_ok |=> (!sw_en && !flag_n));

  // R6
  dis_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s == MD_DIS && mode_prev == MD_DIS) |-> !sw_en);

  // R2
  sw_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sw_en) && $past(mode_s) != MD_REV) |-> $past(tick));

  // R3
  flag_after_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_n) && ($past(mode_s) == MD_ENH || $past(mode_s) == MD_DIR))
      |-> (sw_en && $past(sw_en)));
endmodule

// File: tb/sim_pwr_path_seq.sv
`timescale 1ns/1ps
module sim_pwr_path_seq;
  localparam int T_ON = 30;
  localparam int T_FL = 30;

  logic clk = 0, rst_n = 0, tick = 0;
  logic dir_pin = 1, rev_pin = 1, uv_ok = 1, ov_trip = 0, ov_hi_trip = 0, temp_ok = 1;
  logic sw_en, flag_n;
  int checks = 0, errors = 0, cyc = 0, tdiv = 0;

  int m_s1, m_s2, m_prev, m_ph, m_cnt, m;
  bit m_flt, m_in;

  always #10 clk = ~clk;

  pwr_path_seq #(.T_ON_TICKS(T_ON), .T_FLAG_TICKS(T_FL)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dir_pin(dir_pin), .rev_pin(rev_pin),
    .uv_ok(uv_ok), .ov_trip(ov_trip), .ov_hi_trip(ov_hi_trip), .temp_ok(temp_ok),
    .sw_en(sw_en), .flag_n(flag_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp_v, input string what);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp_v, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic d, input logic r);
    dir_pin = d; rev_pin = r;
  endtask

  always @(negedge clk) begin
    tick <= (tdiv == 3);
    tdiv <= (tdiv + 1) % 4;
  end

  // behavioural reference: phase 0 open, 1 switch delay, 2 flag delay, 3 closed, 4 isolated-good
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 3; m_s2 = 3; m_prev = 3; m_ph = 0; m_cnt = 0;
    end else begin
      m = m_s2;
      m_in  = !uv_ok || ((m == 0) ? ov_hi_trip : ov_trip);
      m_flt = !temp_ok || (m != 2 && m_in);
      if (m_flt || m != m_prev) begin
        m_ph = 0; m_cnt = 0;
      end else begin
        case (m_ph)
          0: m_ph = (m == 3) ? 4 : (m == 2) ? 3 : 1;
          1: if (tick) begin m_cnt++; if (m_cnt == T_ON) begin m_ph = 2; m_cnt = 0; end end
          2: if (tick) begin m_cnt++; if (m_cnt == T_FL) begin m_ph = 3; m_cnt = 0; end end
          default: ;
        endcase
      end
      m_prev = m; m_s2 = m_s1; m_s1 = {dir_pin, rev_pin};
    end
  end

  always @(negedge clk) begin
    string tag;
    cyc++;
    if (!rst_n) tag = "R10";
    else case (m_prev)
      0: tag = "R5";
      1: tag = "R2";
      2: tag = "R7";
      default: tag = "R6";
    endcase
    chk(tag, sw_en, (m_ph == 2 || m_ph == 3), "model sw_en");
    chk(tag, flag_n, (m_ph == 3 || m_ph == 4), "model flag_n");
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    chk("R10", sw_en, 0, "reset sw_en");
    chk("R10", flag_n, 0, "reset flag_n");
    rst_n = 1;
    wait_cyc(5);
    chk("R6", flag_n, 1, "disable healthy flag");
    chk("R6", sw_en, 0, "disable switch open");
    uv_ok = 0; wait_cyc(2);
    chk("R6", flag_n, 0, "disable uv flag");
    uv_ok = 1; wait_cyc(2);
    chk("R6", flag_n, 1, "disable recover flag");

    set_mode(0, 1); wait_cyc(10);
    chk("R2", sw_en, 0, "direct delay running");
    wait_cyc(200);
    chk("R2", sw_en, 1, "direct switch closed");
    chk("R3", flag_n, 0, "flag still low");
    wait_cyc(100);
    chk("R3", flag_n, 1, "flag raised");
    ov_hi_trip = 1; wait_cyc(3);
    chk("R5", sw_en, 1, "direct ignores raised ov");
    ov_hi_trip = 0;
    ov_trip = 1; wait_cyc(2);
    chk("R4", sw_en, 0, "ov opens switch");
    chk("R4", flag_n, 0, "ov drops flag");
    ov_trip = 0; wait_cyc(60);
    chk("R4", sw_en, 0, "delay restarted");
    uv_ok = 0; wait_cyc(1); uv_ok = 1;
    wait_cyc(100);
    chk("R4", sw_en, 0, "mid-delay fault restarts");
    wait_cyc(200);
    chk("R4", flag_n, 1, "recovered after fault");

    set_mode(0, 0); wait_cyc(3);
    chk("R9", sw_en, 0, "mode change opens");
    ov_trip = 1; wait_cyc(300);
    chk("R5", sw_en, 1, "enhance ignores normal ov");
    chk("R5", flag_n, 1, "enhance flag high");
    ov_hi_trip = 1; wait_cyc(2);
    chk("R5", sw_en, 0, "enhance raised ov opens");
    ov_hi_trip = 0; ov_trip = 0; wait_cyc(60);
    set_mode(0, 1); wait_cyc(100);
    chk("R9", sw_en, 0, "aborted delay restarted");

    set_mode(1, 0); uv_ok = 0; ov_trip = 1; wait_cyc(6);
    chk("R7", sw_en, 1, "reverse closes ignoring comparators");
    chk("R7", flag_n, 1, "reverse flag high");
    temp_ok = 0; wait_cyc(2);
    chk("R8", sw_en, 0, "thermal opens");
    chk("R8", flag_n, 0, "thermal drops flag");
    temp_ok = 1; wait_cyc(3);
    chk("R8", sw_en, 1, "thermal recovery");
    uv_ok = 1; ov_trip = 0; wait_cyc(1);

    set_mode(1, 1); wait_cyc(2);
    chk("R1", sw_en, 1, "sync latency holds old mode");
    wait_cyc(1);
    chk("R1", sw_en, 0, "new mode acts on third edge");
    temp_ok = 0; wait_cyc(2);
    chk("R8", flag_n, 0, "thermal in disable");
    temp_ok = 1; wait_cyc(3);
    chk("R6", flag_n, 1, "disable healthy again");
    wait_cyc(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule